// File: doc/BRIEF.md
# Interconnect Request Error Monitor

This block sits beside one port of a packet-based on-chip interconnect and judges every request that arrives there. Each request is a one-cycle descriptor made of a type code, a size code and a bit saying whether the requester waits for a response. Requests of an unsupported type, and reads or writes that would need more than one data packet, are counted as errors. Two clock-lock status inputs are watched as well. They are synchronized first, and a lock seen while power-on reset is not active is also counted as an error.

Each error class owns a sticky flag in a 64-bit status/mask word. Software reaches the word through a simple read/write port. A flag is cleared by writing 1 to it. Four mask bits in the low half of the word silence the matching classes. The block drives a level error output that stays high while any unmasked flag is set. When a bad request expects a response, the response carries an exception bit one cycle later. When no response is expected, only the flag and the error output report the error.

Top module: `req_err_monitor`

## Requirements
- R1: After reset, the read word is all zeros, and errOut, rspValid and rspExc are all 0.
- R2: The type codes are NULL=0, READ=1, WRITE=2, START_BEX=3, SNOOP=4, PEEK_WR=5, DEBUG=6 and MSG=7. A valid request with type 0, 3, 4, 5 or 6 sets the type flag (bit 32), and the flag reads 1 after the clock edge that samples the request. Types 1, 2 and 7 never set it.
- R3: The size codes are 0=8 bytes, 1=16 bytes, 2=32 bytes and 3=4 bytes. A valid READ or WRITE request with size code 1 or 2 sets the size flag (bit 33) after the sampling edge. No other pair of type and size sets it.
- R4: On the edge after a valid request with reqRespExp=1, rspValid goes to 1. At the same edge rspExc goes to 1 only if that request raised a type or size error. A request with reqRespExp=0 gives rspValid=0 and rspExc=0, yet still sets its flags.
- R5: Each lock input passes through two synchronizing flops. A lock seen at the last flop while porActive=0 sets the system flag (bit 35) or the display-clock flag (bit 34), so the flag reads 1 three edges after the input rises. A lock seen while porActive=1 sets nothing.
- R6: A write with 1 in any of bits 35:32 clears that flag. A 0 in those bits leaves the flag as it was.
- R7: If a detection and a write-one-clear hit the same flag at the same edge, the flag ends up set.
- R8: Bits 3:0 are plain read/write mask bits. Bits 3, 2, 1 and 0 mask the flags at bits 35, 34, 33 and 32, in that order. Every write loads bits 3:0 from the write data.
- R9: errOut is 1 exactly when some flag is set and its mask bit is 0. It stays 1 until every unmasked flag has been cleared or masked.
- R10: Bits 63:36 and 31:4 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| porActive | input | 1 | Power-on reset still active (synchronous to clk) |
| sysLockAsync | input | 1 | System clock PLL lock, asynchronous |
| dotLockAsync | input | 1 | Display clock PLL lock, asynchronous |
| reqValid | input | 1 | Request descriptor present this cycle |
| reqType | input | 3 | Request type code |
| reqSize | input | 2 | Request size code |
| reqRespExp | input | 1 | Requester expects a response |
| regWrEn | input | 1 | Write strobe for the status/mask word |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Current status/mask word |
| errOut | output | 1 | Masked error indication |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspExc | output | 1 | Exception bit on that response |

## Verification
A request-driven detection can land on the same edge as a software write-one-clear of the same flag. Both can also coincide with a write that changes the masks. The bench provokes this on purpose: it issues a bad-type request in the same cycle as a write of all ones to the flag bits. It expects the flag still set afterwards, and it expects errOut to follow the newly written mask. Random cycles then mix writes, requests and lock changes freely. Every readback is compared with a model that applies the set-wins rule at each edge.

// File: rtl/req_err_pkg.sv
package req_err_pkg;
  localparam int FLAG_N = 4;
  localparam int TYPE_W = 3;
  localparam int SIZE_W = 2;

  // flag index inside the flag field
  localparam int F_TYPE = 0;
  localparam int F_SIZE = 1;
  localparam int F_DOT  = 2;
  localparam int F_SYS  = 3;

  typedef enum logic [TYPE_W-1:0] {
    TY_NULL = 3'd0, TY_READ = 3'd1, TY_WRITE = 3'd2, TY_START_BEX = 3'd3,
    TY_SNOOP = 3'd4, TY_PEEK_WR = 3'd5, TY_DEBUG = 3'd6, TY_MSG = 3'd7
  } reqType_e;

  typedef enum logic [SIZE_W-1:0] {
    SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_4 = 2'd3
  } reqSize_e;

  typedef struct packed {
    logic [FLAG_N-1:0] setFlag;
    logic [FLAG_N-1:0] clrFlag;
    logic              maskWr;
    logic [FLAG_N-1:0] maskVal;
  } strobe_t;
endpackage

// File: rtl/req_err_ctrl.sv
module req_err_ctrl
  import req_err_pkg::*;
#(
  parameter int REG_W       = 64,
  parameter int FLAG_LSB    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porActive,
  input  logic              sysLockAsync,
  input  logic              dotLockAsync,
  input  logic              reqValid,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqRespExp,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output strobe_t           strb,
  output logic              rspValid,
  output logic              rspExc
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sysPipe, dotPipe;
  logic lockSys, lockDot, badType, badSize, isRdWr, isMulti;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysPipe <= '0;
      dotPipe <= '0;
    end else begin
      sysPipe <= {sysPipe[SYNC_STAGES-2:0], sysLockAsync};
      dotPipe <= {dotPipe[SYNC_STAGES-2:0], dotLockAsync};
    end
  end
  assign lockSys = sysPipe[LAST];
  assign lockDot = dotPipe[LAST];

  always_comb begin
    isRdWr  = (reqType == TY_READ) || (reqType == TY_WRITE);
    isMulti = (reqSize == SZ_16) || (reqSize == SZ_32);
    badSize = reqValid && isRdWr && isMulti;
    badType = reqValid && ((reqType == TY_NULL) || (reqType == TY_START_BEX) ||
                           (reqType == TY_SNOOP) || (reqType == TY_PEEK_WR) ||
                           (reqType == TY_DEBUG));
  end

  always_comb begin
    strb.setFlag         = '0;
    strb.setFlag[F_TYPE] = badType;
    strb.setFlag[F_SIZE] = badSize;
    strb.setFlag[F_DOT]  = lockDot && !porActive;
    strb.setFlag[F_SYS]  = lockSys && !porActive;
    strb.clrFlag         = regWrEn ? regWrData[FLAG_LSB +: FLAG_N] : '0;
    strb.maskWr          = regWrEn;
    strb.maskVal         = regWrData[FLAG_N-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspExc   <= 1'b0;
    end else begin
      rspValid <= reqValid && reqRespExp;
      rspExc   <= reqValid && reqRespExp && (badType || badSize);
    end
  end

  AST_EXC_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    rspExc |-> rspValid); // R4
  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqRespExp) |=> rspValid); // R4
endmodule

// File: rtl/req_err_regs.sv
module req_err_regs
  import req_err_pkg::*;
#(
  parameter int REG_W    = 64,
  parameter int FLAG_LSB = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic [REG_W-1:0] regRdData,
  output logic             errOut
);
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] mask;

  for (genvar i = 0; i < FLAG_N; i++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN)                  flags[i] <= 1'b0;
      else if (strb.setFlag[i])   flags[i] <= 1'b1;
      else if (strb.clrFlag[i])   flags[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strb.setFlag[i] |=> flags[i]); // R7
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrFlag[i] && !strb.setFlag[i]) |=> !flags[i]); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (flags[i] && !strb.clrFlag[i]) |=> flags[i]); // R6
  end

  always_ff @(posedge clk) begin
    if (!rstN)            mask <= '0;
    else if (strb.maskWr) mask <= strb.maskVal;
  end

  always_comb begin
    regRdData                      = '0;
    regRdData[FLAG_LSB +: FLAG_N]  = flags;
    regRdData[FLAG_N-1:0]          = mask;
  end

  assign errOut = |(flags & ~mask);
endmodule

// File: rtl/req_err_monitor.sv
module req_err_monitor
  import req_err_pkg::*;
#(
  parameter int REG_W       = 64,
  parameter int FLAG_LSB    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porActive,
  input  logic              sysLockAsync,
  input  logic              dotLockAsync,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [1:0]        reqSize,
  input  logic              reqRespExp,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              errOut,
  output logic              rspValid,
  output logic              rspExc
);
  strobe_t strb;

  req_err_ctrl #(.REG_W(REG_W), .FLAG_LSB(FLAG_LSB), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .porActive(porActive),
    .sysLockAsync(sysLockAsync), .dotLockAsync(dotLockAsync),
    .reqValid(reqValid), .reqType(reqType), .reqSize(reqSize),
    .reqRespExp(reqRespExp), .regWrEn(regWrEn), .regWrData(regWrData),
    .strb(strb), .rspValid(rspValid), .rspExc(rspExc)
  );

  req_err_regs #(.REG_W(REG_W), .FLAG_LSB(FLAG_LSB)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .regRdData(regRdData), .errOut(errOut)
  );

  AST_NULL_TYPE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqType == TY_NULL) |=> regRdData[FLAG_LSB + F_TYPE]); // R2
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&regRdData[FLAG_N-1:0]) |-> !errOut); // R9
endmodule

// File: tb/sim_req_err_monitor.sv
`timescale 1ns/1ps
module sim_req_err_monitor;
  logic clk = 1'b0;
  logic rstN, porActive, sysLockAsync, dotLockAsync;
  logic reqValid, reqRespExp, regWrEn;
  logic [2:0] reqType;
  logic [1:0] reqSize;
  logic [63:0] regWrData, regRdData;
  logic errOut, rspValid, rspExc;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [3:0] mFlags, mMask;
  logic [1:0] mSys, mDot;
  logic mRv, mRx;

  always #10 clk = ~clk;

  req_err_monitor u0 (
    .clk(clk), .rstN(rstN), .porActive(porActive),
    .sysLockAsync(sysLockAsync), .dotLockAsync(dotLockAsync),
    .reqValid(reqValid), .reqType(reqType), .reqSize(reqSize),
    .reqRespExp(reqRespExp), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .errOut(errOut), .rspValid(rspValid), .rspExc(rspExc)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expWord(logic [3:0] f, logic [3:0] m);
    return {28'd0, f, 28'd0, m};
  endfunction

  task automatic checkAll(string tag);
    chk(tag, "readback", regRdData, expWord(mFlags, mMask));
    chk(tag, "errOut", {63'd0, errOut}, {63'd0, |(mFlags & ~mMask)});
    chk(tag, "rspValid", {63'd0, rspValid}, {63'd0, mRv});
    chk(tag, "rspExc", {63'd0, rspExc}, {63'd0, mRx});
  endtask

  task automatic step(string tag, bit pa, bit sl, bit dl, bit v, logic [2:0] t,
                      logic [1:0] s, bit re, bit we, logic [63:0] wd);
    logic bt, bs;
    logic [3:0] setV, clrV, nFlags, nMask;
    porActive = pa; sysLockAsync = sl; dotLockAsync = dl;
    reqValid = v; reqType = t; reqSize = s; reqRespExp = re;
    regWrEn = we; regWrData = wd;
    bt = v && (t == 3'd0 || t == 3'd3 || t == 3'd4 || t == 3'd5 || t == 3'd6);
    bs = v && (t == 3'd1 || t == 3'd2) && (s == 2'd1 || s == 2'd2);
    setV = {mSys[1] & ~pa, mDot[1] & ~pa, bs, bt};
    clrV = we ? wd[35:32] : 4'd0;
    nFlags = setV | (mFlags & ~clrV);
    nMask = we ? wd[3:0] : mMask;
    @(posedge clk);
    mFlags = nFlags; mMask = nMask;
    mSys = {mSys[0], sl}; mDot = {mDot[0], dl};
    mRv = v && re; mRx = v && re && (bt || bs);
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 64'd0);
  endtask

  task automatic clearAll(string tag);
    step(tag, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, {28'd0, 4'hF, 28'd0, mMask});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; porActive = 1'b1; sysLockAsync = 1'b0; dotLockAsync = 1'b0;
    reqValid = 1'b0; reqType = 3'd0; reqSize = 2'd0; reqRespExp = 1'b0;
    regWrEn = 1'b0; regWrData = '0;
    mFlags = '0; mMask = '0; mSys = '0; mDot = '0; mRv = 1'b0; mRx = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkAll("R1 reset");
    idle("R1 idle");

    // R2: every type code, response expected
    for (int t = 0; t < 8; t++) begin
      step("R2 type", 1'b0, 1'b0, 1'b0, 1'b1, 3'(t), 2'd0, 1'b1, 1'b0, 64'd0);
      clearAll("R2 clr");
    end
    // R3: size codes against read, write and message
    for (int t = 1; t < 8; t = t + 1) begin
      if (t == 1 || t == 2 || t == 7)
        for (int s = 0; s < 4; s++) begin
          step("R3 size", 1'b0, 1'b0, 1'b0, 1'b1, 3'(t), 2'(s), 1'b1, 1'b0, 64'd0);
          clearAll("R3 clr");
        end
    end
    // R4: no response expected, flag still set
    step("R4 noresp", 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 2'd0, 1'b0, 1'b0, 64'd0);
    step("R4 noresp size", 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 2'd2, 1'b0, 1'b0, 64'd0);
    // R6: write zeros leaves flags, then partial clear
    step("R6 zero write", 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 64'd0);
    step("R6 clear type", 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 64'h1_0000_0000);
    clearAll("R6 clr");
    // R5: lock during power-on reset sets nothing
    for (int k = 0; k < 5; k++)
      step("R5 por", 1'b1, 1'b1, 1'b1, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 64'd0);
    step("R5 por release", 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 64'd0);
    for (int k = 0; k < 4; k++) idle("R5 settle");
    for (int k = 0; k < 4; k++)
      step("R5 sys lock", 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 64'd0);
    for (int k = 0; k < 3; k++) idle("R5 drain");
    clearAll("R5 clr");
    for (int k = 0; k < 4; k++)
      step("R5 dot lock", 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 2'd0, 1'b0, 1'b0, 64'd0);
    for (int k = 0; k < 3; k++) idle("R5 drain");
    clearAll("R5 clr");
    // R7: detection and clear on the same edge, with mask change
    step("R7 set wins", 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 2'd0, 1'b1, 1'b1, {28'd0, 4'hF, 28'd0, 4'h2});
    step("R7 set wins size", 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 2'd1, 1'b1, 1'b1, {28'd0, 4'hF, 28'd0, 4'h0});
    // R8 / R9: masks silence errOut, then unmask one
    step("R8 mask all", 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 64'h0000_0000_0000_000F);
    step("R9 unmask size", 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 64'h0000_0000_0000_000D);
    step("R9 clear size", 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 64'h0000_0002_0000_000D);
    // R10: reserved bits
    step("R10 rsvd", 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 64'hFFFF_FFF0_FFFF_FFF5);
    step("R10 rsvd2", 1'b0, 1'b0, 1'b0, 1'b1, 3'd6, 2'd0, 1'b1, 1'b1, 64'hFFFF_FFF0_FFFF_FFF0);
    clearAll("R10 clr");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit pa, sl, dl, v, re, we;
      logic [63:0] wd;
      pa = ($urandom % 8) == 0;
      sl = ($urandom % 6) == 0;
      dl = ($urandom % 6) == 0;
      v  = ($urandom % 3) != 0;
      re = $urandom % 2;
      we = ($urandom % 4) == 0;
      wd = {$urandom, $urandom};
      step("R2 R3 R6 R9 random", pa, sl, dl, v, 3'($urandom % 8), 2'($urandom % 4), re, we, wd);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule